// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block is the status side of a NOR-style flash device whose program and erase work is carried out by internal algorithms. It watches the host bus (chip enable, output enable, write enable, command byte and a sector tag), decodes the multi-write command sequences that start a program, a sector erase, a chip erase, an erase suspend or an erase resume, and tracks which embedded operation is running. An external algorithm timer ends each operation with a one-clock done pulse.

While an operation runs, the host polls by reading. On each read the block returns two status bits. The host compares two successive reads to see whether an operation is in progress, whether it is a program or an erase, whether erase is suspended, and which sector is the erasing one. An active-low ready/busy output gives the same information without polling. Bus pins are sampled on the system clock. A write or a read completes on the clock edge that sees the enable return high while chip enable is low.

Top module: `flash_status_reporter`

## Requirements
- R1: A program sequence is four completed writes with command bytes 0xAA, 0x55, 0xA0 and then any data byte. ry_by goes low on the clock edge after the fourth write completes.
- R2: A sector erase sequence is six completed writes with bytes 0xAA, 0x55, 0x80, 0xAA, 0x55, 0x30. The sector tag on the sixth write names the erasing sector. If the sixth byte is 0x10, the erase is a chip erase and every sector counts as erasing. ry_by goes low on the edge after the sixth write.
- R3: While a program or an erase is busy, completed writes start no new operation. The one exception is the suspend byte 0xB0 during erase.
- R4: Writing 0xB0 during an erase enters erase-suspend, and ry_by is high on the next edge. Writing 0x30 as a lone command while suspended resumes the erase and drives ry_by low.
- R5: While rst is high, ry_by is low. After reset the block is in read mode with ry_by high and dq6 = dq2 = 0.
- R6: During a program, dq6 changes on each successive read of any sector and dq2 reads 1.
- R7: During an erase, a read of an erasing sector toggles both dq6 and dq2. A read of any other sector toggles dq6, and dq2 reads 1 for that sector.
- R8: In erase-suspend, a read of the suspended sector returns dq6 = 1 and a toggling dq2. Reads of other sectors, and all reads in read mode, return dq6 = dq2 = 0.
- R9: A program sequence written while suspended starts a suspended program. ry_by goes low, dq6 toggles on each read and dq2 reads 1. Its done pulse returns the block to erase-suspend.
- R10: Both toggle bits are 0 after reset. They change only when a read completes with chip enable low, so an output-enable pulse with chip enable high changes nothing.
- R11: A done pulse during a program or an active erase returns the block to read mode and drives ry_by high on the next clock edge.
- R12: A byte that does not match the expected step of a sequence sends the decoder back to the first step, and no operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; rising edge completes a read |
| we_n | input | 1 | Write enable, active low; rising edge completes a write |
| sector_addr | input | SECT_W | Sector tag of the current read or write |
| cmd_data | input | 8 | Command byte on writes |
| alg_done | input | 1 | One-clock end pulse from the algorithm timer |
| ry_by | output | 1 | Ready (1) / busy (0) |
| dq6 | output | 1 | Toggle status bit |
| dq2 | output | 1 | Sector toggle status bit |

## Verification
A wrong operating mode appears at ry_by on the clock edge after the write or done pulse that caused it. It also changes the dq6/dq2 pattern of the very next poll. A toggle bit that flips when it should not, or fails to flip, shows as two equal or two unequal successive reads, and that is detected on the second read. A wrong active sector shows only when a read falls on the erasing sector or a neighbouring one. For that reason the random polling mixes both kinds of address and includes chip erase.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    M_READ, M_PGM, M_ERS, M_SUSP, M_SPGM
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PDATA, S_E1, S_E2, S_E3
  } step_t;

  localparam logic [7:0] B_UNLOCK1 = 8'hAA;
  localparam logic [7:0] B_UNLOCK2 = 8'h55;
  localparam logic [7:0] B_PROG    = 8'hA0;
  localparam logic [7:0] B_ERSETUP = 8'h80;
  localparam logic [7:0] B_SECTER  = 8'h30;
  localparam logic [7:0] B_CHIPER  = 8'h10;
  localparam logic [7:0] B_SUSPEND = 8'hB0;
  localparam logic [7:0] B_RESUME  = 8'h30;

  function automatic logic is_busy(input mode_t m);
    return (m == M_PGM) || (m == M_ERS) || (m == M_SPGM);
  endfunction
endpackage

// File: rtl/fsr_cmd_seq.sv
module fsr_cmd_seq
  import fsr_pkg::*;
#(
  parameter int SECT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  input  logic [SECT_W-1:0] wr_sector,
  input  logic              alg_done,
  output mode_t             mode_o,
  output logic [SECT_W-1:0] act_sector_o,
  output logic              erase_all_o,
  output logic              ry_by_o
);
  mode_t              mode_q, mode_n;
  step_t              step_q, step_n;
  logic [SECT_W-1:0]  sect_q, sect_n;
  logic               all_q, all_n;
  logic               ry_q;

  always_comb begin
    mode_n = mode_q;
    step_n = step_q;
    sect_n = sect_q;
    all_n  = all_q;
    if (alg_done) begin
      unique case (mode_q)
        M_PGM, M_ERS: begin mode_n = M_READ; step_n = S_IDLE; end
        M_SPGM:       begin mode_n = M_SUSP; step_n = S_IDLE; end
        default: ;
      endcase
    end else if (wr_stb) begin
      unique case (mode_q)
        M_ERS: if (wr_data == B_SUSPEND) mode_n = M_SUSP;
        M_READ, M_SUSP: begin
          step_n = S_IDLE;
          unique case (step_q)
            S_IDLE: begin
              if (wr_data == B_UNLOCK1) step_n = S_U1;
              else if (mode_q == M_SUSP && wr_data == B_RESUME) mode_n = M_ERS;
            end
            S_U1: if (wr_data == B_UNLOCK2) step_n = S_U2;
            S_U2: begin
              if (wr_data == B_PROG) step_n = S_PDATA;
              else if (wr_data == B_ERSETUP && mode_q == M_READ) step_n = S_E1;
            end
            S_PDATA: mode_n = (mode_q == M_READ) ? M_PGM : M_SPGM;
            S_E1: if (wr_data == B_UNLOCK1) step_n = S_E2;
            S_E2: if (wr_data == B_UNLOCK2) step_n = S_E3;
            S_E3: begin
              if (wr_data == B_SECTER) begin
                mode_n = M_ERS; sect_n = wr_sector; all_n = 1'b0;
              end else if (wr_data == B_CHIPER) begin
                mode_n = M_ERS; all_n = 1'b1;
              end
            end
            default: step_n = S_IDLE;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_READ;
      step_q <= S_IDLE;
      sect_q <= '0;
      all_q  <= 1'b0;
      ry_q   <= 1'b0;
    end else begin
      mode_q <= mode_n;
      step_q <= step_n;
      sect_q <= sect_n;
      all_q  <= all_n;
      ry_q   <= !is_busy(mode_n);
    end
  end

  assign mode_o       = mode_q;
  assign act_sector_o = sect_q;
  assign erase_all_o  = all_q;
  assign ry_by_o      = ry_q;

  a_r1_pgm_busy: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_READ && step_q == S_PDATA && wr_stb && !alg_done) |=> (!ry_q && mode_q == M_PGM));
  a_r2_ers_busy: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_READ && step_q == S_E3 && wr_stb && !alg_done && wr_data == B_SECTER)
      |=> (!ry_q && mode_q == M_ERS));
  a_r3_pgm_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PGM && !alg_done) |=> (mode_q == M_PGM));
  a_r4_susp_ready: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SUSP) |-> ry_q);
  a_r11_done_ready: assert property (@(posedge clk) disable iff (rst)
    (alg_done && (mode_q == M_PGM || mode_q == M_ERS)) |=> (ry_q && mode_q == M_READ));
endmodule

// File: rtl/fsr_toggle_status.sv
module fsr_toggle_status
  import fsr_pkg::*;
#(
  parameter int SECT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_t             mode_i,
  input  logic [SECT_W-1:0] act_sector_i,
  input  logic              erase_all_i,
  input  logic              rd_done,
  input  logic [SECT_W-1:0] rd_sector,
  output logic              dq6_o,
  output logic              dq2_o
);
  logic t6_q, t2_q, dq6_q, dq2_q;
  logic hit;

  assign hit = erase_all_i || (rd_sector == act_sector_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      t6_q  <= 1'b0;
      t2_q  <= 1'b0;
      dq6_q <= 1'b0;
      dq2_q <= 1'b0;
    end else begin
      if (rd_done) begin
        unique case (mode_i)
          M_PGM, M_SPGM: t6_q <= ~t6_q;
          M_ERS: begin
            t6_q <= ~t6_q;
            if (hit) t2_q <= ~t2_q;
          end
          M_SUSP: if (hit) t2_q <= ~t2_q;
          default: ;
        endcase
      end
      unique case (mode_i)
        M_PGM, M_SPGM: begin dq6_q <= t6_q; dq2_q <= 1'b1; end
        M_ERS:         begin dq6_q <= t6_q; dq2_q <= hit ? t2_q : 1'b1; end
        M_SUSP:        begin dq6_q <= hit;  dq2_q <= hit & t2_q; end
        default:       begin dq6_q <= 1'b0; dq2_q <= 1'b0; end
      endcase
    end
  end

  assign dq6_o = dq6_q;
  assign dq2_o = dq2_q;

  a_r10_no_read_no_flip: assert property (@(posedge clk) disable iff (rst)
    !rd_done |=> ($stable(t6_q) && $stable(t2_q)));
  a_r6_pgm_flip: assert property (@(posedge clk) disable iff (rst)
    (rd_done && mode_i == M_PGM) |=> (t6_q != $past(t6_q)));
  a_r8_susp_dq6_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode_i == M_SUSP) |=> $stable(t6_q));
endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter
  import fsr_pkg::*;
#(
  parameter int SECT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [SECT_W-1:0] sector_addr,
  input  logic [7:0]        cmd_data,
  input  logic              alg_done,
  output logic              ry_by,
  output logic              dq6,
  output logic              dq2
);
  logic              we_q, oe_q;
  logic              wr_stb, rd_done;
  mode_t             mode;
  logic [SECT_W-1:0] act_sector;
  logic              erase_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end
  end

  assign wr_stb  = we_n & ~we_q & ~ce_n;
  assign rd_done = oe_n & ~oe_q & ~ce_n;

  fsr_cmd_seq #(.SECT_W(SECT_W)) u_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(cmd_data),
    .wr_sector(sector_addr), .alg_done(alg_done), .mode_o(mode),
    .act_sector_o(act_sector), .erase_all_o(erase_all), .ry_by_o(ry_by)
  );

  fsr_toggle_status #(.SECT_W(SECT_W)) u_tog (
    .clk(clk), .rst(rst), .mode_i(mode), .act_sector_i(act_sector),
    .erase_all_i(erase_all), .rd_done(rd_done), .rd_sector(sector_addr),
    .dq6_o(dq6), .dq2_o(dq2)
  );

  a_r5_reset_busy: assert property (@(posedge clk) rst |=> !ry_by);
endmodule

// File: tb/flash_status_reporter_tb.sv
module flash_status_reporter_tb;
  localparam int SW = 6;
  localparam int MR = 0, MP = 1, ME = 2, MS = 3, MSP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, alg_done = 1'b0;
  logic [SW-1:0] sector_addr = '0;
  logic [7:0] cmd_data = '0;
  logic ry_by, dq6, dq2;

  int n_chk = 0, n_fail = 0;
  int bm = MR;
  int bsec = 0;
  bit ball = 1'b0, m6 = 1'b0, m2 = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_reporter #(.SECT_W(SW)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .sector_addr(sector_addr), .cmd_data(cmd_data), .alg_done(alg_done),
    .ry_by(ry_by), .dq6(dq6), .dq2(dq2)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_st(input int md, input bit hit, input bit t6, input bit t2);
    case (md)
      MP, MSP: return {t6, 1'b1};
      ME:      return {t6, hit ? t2 : 1'b1};
      MS:      return {hit, hit & t2};
      default: return 2'b00;
    endcase
  endfunction

  task automatic wr(input logic [7:0] d, input int sec);
    @(negedge clk);
    ce_n = 1'b0; cmd_data = d; sector_addr = SW'(sec); we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input string tag, input int sec);
    bit hit;
    hit = ball || (sec == bsec);
    @(negedge clk);
    ce_n = 1'b0; sector_addr = SW'(sec); oe_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(tag, {dq6, dq2}, exp_st(bm, hit, m6, m2));
    oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    case (bm)
      MP, MSP: m6 = ~m6;
      ME: begin m6 = ~m6; if (hit) m2 = ~m2; end
      MS: if (hit) m2 = ~m2;
      default: ;
    endcase
  endtask

  task automatic done_pulse();
    @(negedge clk); alg_done = 1'b1;
    @(negedge clk); alg_done = 1'b0;
    bm = (bm == MSP) ? MS : MR;
  endtask

  task automatic program_seq(input int sec);
    wr(8'hAA, sec); wr(8'h55, sec); wr(8'hA0, sec); wr(8'h3C, sec);
  endtask

  task automatic erase_seq(input int sec, input bit chip);
    wr(8'hAA, 0); wr(8'h55, 0); wr(8'h80, 0); wr(8'hAA, 0); wr(8'h55, 0);
    wr(chip ? 8'h10 : 8'h30, sec);
    bsec = sec; ball = chip;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd51873));
    repeat (3) @(negedge clk);
    chk("R5 busy during reset", {1'b0, ry_by}, 2'b00);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 ready after reset", {1'b0, ry_by}, 2'b01);
    rd("R5 read mode status", 5);

    // R12: bad third byte aborts
    wr(8'hAA, 0); wr(8'h55, 0); wr(8'h77, 0); wr(8'hA0, 0); wr(8'h12, 0);
    chk("R12 aborted sequence stays ready", {1'b0, ry_by}, 2'b01);

    // R1: three writes do not yet assert busy
    wr(8'hAA, 0); wr(8'h55, 0); wr(8'hA0, 0);
    chk("R1 ready after third write", {1'b0, ry_by}, 2'b01);
    wr(8'h99, 0); bm = MP;
    chk("R1 busy after fourth write", {1'b0, ry_by}, 2'b00);
    rd("R6 program poll a", 1); rd("R6 program poll b", 9); rd("R6 program poll c", 1);

    // R10: OE pulse with CE high changes nothing
    @(negedge clk); oe_n = 1'b0; @(negedge clk); oe_n = 1'b1; @(negedge clk);
    rd("R10 no flip without chip enable", 1);

    // R3: erase sequence during program ignored
    erase_seq(4, 1'b0); ball = 1'b0;
    chk("R3 still busy", {1'b0, ry_by}, 2'b00);
    rd("R3 still program status", 4);
    done_pulse();
    chk("R11 ready after done", {1'b0, ry_by}, 2'b01);
    rd("R11 back in read mode", 4);

    // R2: fifth write no busy, sixth busy
    wr(8'hAA, 0); wr(8'h55, 0); wr(8'h80, 0); wr(8'hAA, 0); wr(8'h55, 0);
    chk("R2 ready after fifth write", {1'b0, ry_by}, 2'b01);
    wr(8'h30, 7); bsec = 7; ball = 1'b0; bm = ME;
    chk("R2 busy after sixth write", {1'b0, ry_by}, 2'b00);
    rd("R7 erasing sector a", 7); rd("R7 other sector", 2); rd("R7 erasing sector b", 7);

    // R4 / R8 / R9
    wr(8'hB0, 0); bm = MS;
    chk("R4 suspend is ready", {1'b0, ry_by}, 2'b01);
    rd("R8 suspended sector a", 7); rd("R8 suspended sector b", 7); rd("R8 other sector", 3);
    program_seq(3); bm = MSP;
    chk("R9 suspended program busy", {1'b0, ry_by}, 2'b00);
    rd("R9 suspended program poll a", 3); rd("R9 suspended program poll b", 7);
    done_pulse();
    chk("R9 done returns to suspend", {1'b0, ry_by}, 2'b01);
    rd("R9 suspended sector after program", 7);
    wr(8'h30, 0); bm = ME;
    chk("R4 resume busy", {1'b0, ry_by}, 2'b00);
    rd("R7 resumed erase", 7);
    done_pulse();
    chk("R11 erase done ready", {1'b0, ry_by}, 2'b01);

    // R2 chip erase: every sector erasing
    erase_seq(0, 1'b1); bm = ME;
    rd("R2 chip erase sector 5", 5); rd("R2 chip erase sector 40", 40);
    done_pulse();

    // random mix
    for (int i = 0; i < 30; i++) begin
      int op, sec, nrd;
      op = $urandom % 3; sec = $urandom % 64; nrd = 1 + ($urandom % 4);
      if (op == 0) begin program_seq(sec); bm = MP; end
      else begin erase_seq(sec, op == 2); bm = ME; end
      chk("R1 R2 random busy", {1'b0, ry_by}, 2'b00);
      for (int k = 0; k < nrd; k++) begin
        int rs;
        rs = ($urandom % 2 == 0) ? sec : int'($urandom % 64);
        rd("R6 R7 random poll", rs);
      end
      if (op != 0 && ($urandom % 2 == 0)) begin
        wr(8'hB0, 0); bm = MS;
        chk("R4 random suspend ready", {1'b0, ry_by}, 2'b01);
        rd("R8 random suspend poll", sec);
        rd("R8 random suspend poll other", ($urandom % 2 == 0) ? sec : int'($urandom % 64));
        wr(8'h30, 0); bm = ME;
      end
      done_pulse();
      chk("R11 random done", {1'b0, ry_by}, 2'b01);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule